// File: doc/BRIEF.md
# Exception detection and vectoring unit

This unit sits beside a simple in-order load/store pipeline. Each cycle it looks at the instruction presented for completion: its opcode class, operand size, the low bits of its effective address and, for special-register accesses, the top bit of the encoded register number. From these it finds alignment faults, privilege faults and undefined opcodes. It merges them with reset, machine-check and external-interrupt requests and picks one exception by fixed priority. It then returns the handler fetch address, formed from a base chosen by a status bit and a fixed offset for each exception kind.

When an exception is taken, the unit saves the program counter of the instruction concerned and the old status word. It then clears the privilege and recoverable bits of the live status word. Memory operations follow a precise rule. An access goes out only when no older instruction is still busy and the instruction raises no exception. A late bus error, arriving in the cycle after an issue, aborts that access and raises a machine check on its program counter.

Top module: `exc_vector_unit`

## Requirements
- R1: Synchronous reset (`rst`=1) clears `status`, `save0`, `save1` and the in-flight memory tracking. With no requests, `exc_take`=0, `exc_kind`=0 and `mem_abort`=0.
- R2: `exc_vector` is the base OR the kind offset. The base is 0x00000000 when status.ip=0 and 0xFFF00000 when status.ip=1. The offsets are reset 0x100, machine check 0x200, external 0x500, alignment 0x600, program 0x700 and emulation 0x1000. With no exception, `exc_vector`=0. The status bits are {ip[4], le[3], pr[2], ee[1], ri[0]}.
- R3: Exception kind codes are none 0, reset 1, machine check 2, external 3, alignment 4, program 5 and emulation 6. Priority is reset, then machine check, then the current instruction's fault, then external. An external request is ignored when status.ee=0.
- R4: Opcode class codes are nop 0, alu 1, load 2, store 3, multiple 4, string 5, load-reserve 6, store-conditional 7, supervisor-only 8, special-register 9 and undefined 10. Classes 4, 6 and 7 raise an alignment fault when `ins_ea_lo[1:0]`!=0.
- R5: When status.le=1, a load or store that is not naturally aligned raises an alignment fault, and every multiple or string instruction does too. Size codes are byte 0, half 1, word 2 and double 3.
- R6: When status.le=0, a misaligned plain load or store and any string instruction raise no fault.
- R7: When status.pr=1, class 8 raises a program exception, and so does class 9 with `ins_spr_top`=1. No privilege fault occurs when pr=0, or for class 9 with `ins_spr_top`=0.
- R8: Class 10 raises the emulation exception (kind 6) and never the program exception.
- R9: On the clock edge that ends a cycle with `exc_take`=1, `save0` takes the saved program counter and `save1` takes the old status. The status then loses pr and ri and keeps its other bits. A status write in the same cycle is dropped.
- R10: When no exception is taken, `stat_wr_en`=1 loads `stat_wr_val` into the status at the next edge. Otherwise the status holds.
- R11: `mem_issue`=1 only for a valid memory class (2 to 7) with `older_busy`=0 and `exc_take`=0. While `older_busy`=1, no instruction fault is taken.
- R12: `late_err` in the cycle after an issue drives `mem_abort`=1 and raises a machine check, and `save0` takes the aborted access's program counter. `late_err` has no effect when no access was issued in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the unit |
| rst_req | input | 1 | Reset exception request |
| mchk_req | input | 1 | Machine-check request |
| ext_req | input | 1 | External interrupt request |
| ins_valid | input | 1 | An instruction is presented |
| ins_class | input | 4 | Opcode class code |
| ins_size | input | 2 | Operand size code |
| ins_pc | input | 32 | Program counter of the presented instruction |
| ins_ea_lo | input | 3 | Low bits of the effective address |
| ins_spr_top | input | 1 | Top bit of the encoded special-register number |
| older_busy | input | 1 | An older instruction has not completed |
| late_err | input | 1 | Late bus error for the access issued last cycle |
| stat_wr_en | input | 1 | Status write enable |
| stat_wr_val | input | 5 | Status write value |
| exc_take | output | 1 | An exception is taken this cycle |
| exc_kind | output | 3 | Kind of the exception taken |
| exc_vector | output | 32 | Handler fetch address |
| mem_issue | output | 1 | Memory access issued this cycle |
| mem_abort | output | 1 | The access issued last cycle is aborted |
| save0 | output | 32 | Saved program counter |
| save1 | output | 5 | Saved status word |
| status | output | 5 | Live status word |

## Verification
`exc_take`, `exc_kind`, `exc_vector`, `mem_issue` and `mem_abort` are combinational in the cycle the stimulus is presented. The bench drives at the falling edge and reads them 1 ns later. `save0`, `save1` and `status` change at the next rising edge, so the bench reads them at the falling edge after it. Before it presents an instruction, the bench loads the required status with a write in the previous cycle. A late error is driven in the cycle after the issue cycle, which is the only cycle in which it can abort.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN   = 32;
    localparam int EALO_W = 3;
    localparam int STAT_W = 5;
    localparam logic [XLEN-1:0] HI_BASE = 32'hFFF0_0000;

    typedef enum logic [3:0] {
        CLS_NOP    = 4'd0,
        CLS_ALU    = 4'd1,
        CLS_LOAD   = 4'd2,
        CLS_STORE  = 4'd3,
        CLS_MULTI  = 4'd4,
        CLS_STRING = 4'd5,
        CLS_LDRSV  = 4'd6,
        CLS_STCOND = 4'd7,
        CLS_SUPV   = 4'd8,
        CLS_SPR    = 4'd9,
        CLS_UNDEF  = 4'd10
    } ins_cls_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } op_size_e;

    typedef enum logic [2:0] {
        EXC_NONE  = 3'd0,
        EXC_RESET = 3'd1,
        EXC_MCHK  = 3'd2,
        EXC_EXT   = 3'd3,
        EXC_ALIGN = 3'd4,
        EXC_PROG  = 3'd5,
        EXC_EMU   = 3'd6
    } exc_kind_e;

    typedef struct packed {
        logic ip;
        logic le;
        logic pr;
        logic ee;
        logic ri;
    } stat_t;

    function automatic logic [XLEN-1:0] kind_offset(exc_kind_e k);
        case (k)
            EXC_RESET: return XLEN'(32'h0000_0100);
            EXC_MCHK:  return XLEN'(32'h0000_0200);
            EXC_EXT:   return XLEN'(32'h0000_0500);
            EXC_ALIGN: return XLEN'(32'h0000_0600);
            EXC_PROG:  return XLEN'(32'h0000_0700);
            EXC_EMU:   return XLEN'(32'h0000_1000);
            default:   return '0;
        endcase
    endfunction

    function automatic logic not_natural(logic [EALO_W-1:0] lo, op_size_e sz);
        case (sz)
            SZ_HALF: return lo[0];
            SZ_WORD: return |lo[1:0];
            SZ_DBL:  return |lo;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic is_mem(ins_cls_e c);
        return (c >= CLS_LOAD) && (c <= CLS_STCOND);
    endfunction

endpackage

// File: rtl/exc_fault_detect.sv
module exc_fault_detect
    import exc_pkg::*;
(
    input  logic              active,
    input  ins_cls_e          cls,
    input  op_size_e          size,
    input  logic [EALO_W-1:0] ea_lo,
    input  logic              spr_top,
    input  stat_t             st,
    output logic              flt_align,
    output logic              flt_priv,
    output logic              flt_emu
);
    logic word_off;
    assign word_off = |ea_lo[1:0];

    always_comb begin
        flt_align = 1'b0;
        flt_priv  = 1'b0;
        flt_emu   = 1'b0;
        if (active) begin
            case (cls)
                CLS_LOAD, CLS_STORE:  flt_align = st.le & not_natural(ea_lo, size);
                CLS_MULTI:            flt_align = st.le | word_off;
                CLS_STRING:           flt_align = st.le;
                CLS_LDRSV, CLS_STCOND: flt_align = word_off;
                CLS_SUPV:             flt_priv  = st.pr;
                CLS_SPR:              flt_priv  = st.pr & spr_top;
                CLS_UNDEF:            flt_emu   = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int               AW      = XLEN,
    parameter logic [AW-1:0]    BASE_HI = HI_BASE
) (
    input  logic          rst_req,
    input  logic          mchk,
    input  logic          flt_align,
    input  logic          flt_priv,
    input  logic          flt_emu,
    input  logic          ext_req,
    input  stat_t         st,
    output logic          take,
    output exc_kind_e     kind,
    output logic [AW-1:0] vector
);
    always_comb begin
        kind = EXC_NONE;
        if (rst_req)                 kind = EXC_RESET;
        else if (mchk)               kind = EXC_MCHK;
        else if (flt_align)          kind = EXC_ALIGN;
        else if (flt_priv)           kind = EXC_PROG;
        else if (flt_emu)            kind = EXC_EMU;
        else if (ext_req && st.ee)   kind = EXC_EXT;
    end

    assign take   = (kind != EXC_NONE);
    assign vector = take ? ((st.ip ? BASE_HI : '0) | AW'(kind_offset(kind))) : '0;
endmodule

// File: rtl/exc_mem_guard.sv
module exc_mem_guard
    import exc_pkg::*;
#(
    parameter int AW = XLEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue,
    input  logic [AW-1:0] pc,
    input  logic          late_err,
    output logic          abort,
    output logic [AW-1:0] abort_pc
);
    logic          inflight_q;
    logic [AW-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight_q <= 1'b0;
            pc_q       <= '0;
        end else begin
            inflight_q <= issue;
            if (issue) pc_q <= pc;
        end
    end

    assign abort    = inflight_q & late_err;
    assign abort_pc = pc_q;

    AST_ABORT_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
        abort |-> $past(issue)); // R12
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
    import exc_pkg::*;
#(
    parameter int AW = XLEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [AW-1:0] save_pc,
    input  logic          wr_en,
    input  stat_t         wr_val,
    output stat_t         status_q,
    output logic [AW-1:0] save0_q,
    output stat_t         save1_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            save0_q  <= '0;
            save1_q  <= '0;
        end else if (take) begin
            save0_q     <= save_pc;
            save1_q     <= status_q;
            status_q.pr <= 1'b0;
            status_q.ri <= 1'b0;
        end else if (wr_en) begin
            status_q <= wr_val;
        end
    end

    AST_SAVE_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        take |=> (save0_q == $past(save_pc)) && (save1_q == $past(status_q))); // R9
    AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        take |=> !status_q.pr && !status_q.ri && (status_q.ip == $past(status_q.ip))
                 && (status_q.le == $past(status_q.le))); // R9
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!take && !wr_en) |=> $stable(status_q)); // R10
    AST_STATUS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!take && wr_en) |=> (status_q == $past(wr_val))); // R10
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_req,
    input  logic              mchk_req,
    input  logic              ext_req,
    input  logic              ins_valid,
    input  logic [3:0]        ins_class,
    input  logic [1:0]        ins_size,
    input  logic [XLEN-1:0]   ins_pc,
    input  logic [EALO_W-1:0] ins_ea_lo,
    input  logic              ins_spr_top,
    input  logic              older_busy,
    input  logic              late_err,
    input  logic              stat_wr_en,
    input  logic [STAT_W-1:0] stat_wr_val,
    output logic              exc_take,
    output logic [2:0]        exc_kind,
    output logic [XLEN-1:0]   exc_vector,
    output logic              mem_issue,
    output logic              mem_abort,
    output logic [XLEN-1:0]   save0,
    output logic [STAT_W-1:0] save1,
    output logic [STAT_W-1:0] status
);
    ins_cls_e        cls;
    op_size_e        size;
    stat_t           st_q, sv1_q;
    logic            active, f_align, f_priv, f_emu;
    exc_kind_e       kind;
    logic [XLEN-1:0] abort_pc, save_pc;

    assign cls    = ins_cls_e'(ins_class);
    assign size   = op_size_e'(ins_size);
    assign active = ins_valid & ~older_busy;

    exc_fault_detect u_detect (
        .active(active), .cls(cls), .size(size), .ea_lo(ins_ea_lo),
        .spr_top(ins_spr_top), .st(st_q),
        .flt_align(f_align), .flt_priv(f_priv), .flt_emu(f_emu)
    );

    exc_arbiter #(.AW(XLEN), .BASE_HI(HI_BASE)) u_arb (
        .rst_req(rst_req), .mchk(mchk_req | mem_abort),
        .flt_align(f_align), .flt_priv(f_priv), .flt_emu(f_emu),
        .ext_req(ext_req), .st(st_q),
        .take(exc_take), .kind(kind), .vector(exc_vector)
    );

    assign mem_issue = active & is_mem(cls) & ~exc_take;

    exc_mem_guard #(.AW(XLEN)) u_guard (
        .clk(clk), .rst(rst), .issue(mem_issue), .pc(ins_pc),
        .late_err(late_err), .abort(mem_abort), .abort_pc(abort_pc)
    );

    assign save_pc = (kind == EXC_MCHK && mem_abort) ? abort_pc : ins_pc;

    exc_state_regs #(.AW(XLEN)) u_state (
        .clk(clk), .rst(rst), .take(exc_take), .save_pc(save_pc),
        .wr_en(stat_wr_en), .wr_val(stat_t'(stat_wr_val)),
        .status_q(st_q), .save0_q(save0), .save1_q(sv1_q)
    );

    assign exc_kind = kind;
    assign save1    = sv1_q;
    assign status   = st_q;

    AST_NO_ISSUE_ON_EXC: assert property (@(posedge clk) disable iff (rst)
        mem_issue |-> !exc_take); // R11
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        older_busy |-> !mem_issue && !(kind inside {EXC_ALIGN, EXC_PROG, EXC_EMU})); // R11
    AST_EXT_MASKED: assert property (@(posedge clk) disable iff (rst)
        (kind == EXC_EXT) |-> st_q.ee); // R3
    AST_RESET_FIRST: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (kind == EXC_RESET)); // R3
    AST_VEC_BASE: assert property (@(posedge clk) disable iff (rst)
        exc_take |-> (exc_vector[XLEN-1:20] == (st_q.ip ? HI_BASE[XLEN-1:20] : '0))); // R2
    AST_ABORT_MCHK: assert property (@(posedge clk) disable iff (rst)
        (mem_abort && !rst_req) |-> (kind == EXC_MCHK)); // R12
endmodule

// File: tb/exc_vector_unit_bench.sv
module exc_vector_unit_bench;
    typedef struct packed {
        logic [3:0] cls;
        logic [2:0] ea;
        logic [1:0] sz;
        logic       spr;
        logic [4:0] st;
        logic       q_rst;
        logic       q_mck;
        logic       q_ext;
        logic [2:0] kind;
        logic       issue;
    } vec_t;

    localparam int NV = 24;
    // st = {ip,le,pr,ee,ri}; kind: 0 none 1 reset 2 mchk 3 ext 4 align 5 prog 6 emu
    localparam vec_t VT [NV] = '{
        '{4'd2, 3'd1, 2'd2, 1'b0, 5'b00000, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1}, // R6 load misaligned le=0
        '{4'd2, 3'd2, 2'd2, 1'b0, 5'b01000, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0}, // R5 word at 2, le=1
        '{4'd2, 3'd2, 2'd1, 1'b0, 5'b01000, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1}, // R5 half at 2, le=1
        '{4'd3, 3'd4, 2'd3, 1'b0, 5'b01000, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0}, // R5 double at 4
        '{4'd3, 3'd3, 2'd0, 1'b0, 5'b01000, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1}, // R5 byte never faults
        '{4'd4, 3'd2, 2'd2, 1'b0, 5'b00000, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0}, // R4 multiple off-word
        '{4'd4, 3'd4, 2'd2, 1'b0, 5'b00000, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1}, // R4 multiple aligned
        '{4'd4, 3'd0, 2'd2, 1'b0, 5'b01000, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0}, // R5 multiple le=1
        '{4'd5, 3'd1, 2'd0, 1'b0, 5'b00000, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1}, // R6 string le=0
        '{4'd5, 3'd0, 2'd0, 1'b0, 5'b01000, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0}, // R5 string le=1
        '{4'd6, 3'd2, 2'd2, 1'b0, 5'b00000, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0}, // R4 reserve off-word
        '{4'd7, 3'd1, 2'd2, 1'b0, 5'b10000, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0}, // R4 R2 high base
        '{4'd8, 3'd0, 2'd0, 1'b0, 5'b00100, 1'b0, 1'b0, 1'b0, 3'd5, 1'b0}, // R7 supervisor-only, user
        '{4'd8, 3'd0, 2'd0, 1'b0, 5'b00000, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0}, // R7 supervisor mode
        '{4'd9, 3'd0, 2'd0, 1'b1, 5'b00100, 1'b0, 1'b0, 1'b0, 3'd5, 1'b0}, // R7 spr top set, user
        '{4'd9, 3'd0, 2'd0, 1'b0, 5'b00100, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0}, // R7 spr top clear
        '{4'd9, 3'd0, 2'd0, 1'b1, 5'b00000, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0}, // R7 spr top, supervisor
        '{4'd10,3'd0, 2'd0, 1'b0, 5'b10100, 1'b0, 1'b0, 1'b0, 3'd6, 1'b0}, // R8 undefined, high base
        '{4'd1, 3'd0, 2'd0, 1'b0, 5'b00010, 1'b0, 1'b0, 1'b1, 3'd3, 1'b0}, // R3 external enabled
        '{4'd1, 3'd0, 2'd0, 1'b0, 5'b00000, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0}, // R3 external masked
        '{4'd6, 3'd1, 2'd2, 1'b0, 5'b00010, 1'b0, 1'b0, 1'b1, 3'd4, 1'b0}, // R3 fault over external
        '{4'd2, 3'd1, 2'd2, 1'b0, 5'b01000, 1'b0, 1'b1, 1'b0, 3'd2, 1'b0}, // R3 mchk over fault
        '{4'd1, 3'd0, 2'd0, 1'b0, 5'b10000, 1'b1, 1'b1, 1'b1, 3'd1, 1'b0}, // R3 reset over all
        '{4'd0, 3'd0, 2'd0, 1'b0, 5'b11111, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0}  // R10 nothing pending
    };

    logic        clk = 1'b0;
    logic        rst, rst_req, mchk_req, ext_req, ins_valid, ins_spr_top;
    logic        older_busy, late_err, stat_wr_en;
    logic [3:0]  ins_class;
    logic [1:0]  ins_size;
    logic [31:0] ins_pc;
    logic [2:0]  ins_ea_lo;
    logic [4:0]  stat_wr_val;
    logic        exc_take, mem_issue, mem_abort;
    logic [2:0]  exc_kind;
    logic [31:0] exc_vector, save0;
    logic [4:0]  save1, status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    exc_vector_unit u_exc_vector_unit (
        .clk(clk), .rst(rst), .rst_req(rst_req), .mchk_req(mchk_req), .ext_req(ext_req),
        .ins_valid(ins_valid), .ins_class(ins_class), .ins_size(ins_size), .ins_pc(ins_pc),
        .ins_ea_lo(ins_ea_lo), .ins_spr_top(ins_spr_top), .older_busy(older_busy),
        .late_err(late_err), .stat_wr_en(stat_wr_en), .stat_wr_val(stat_wr_val),
        .exc_take(exc_take), .exc_kind(exc_kind), .exc_vector(exc_vector),
        .mem_issue(mem_issue), .mem_abort(mem_abort), .save0(save0), .save1(save1),
        .status(status)
    );

    function automatic logic [31:0] exp_vec(logic [2:0] k, logic ip);
        logic [31:0] off;
        case (k)
            3'd1: off = 32'h100;
            3'd2: off = 32'h200;
            3'd3: off = 32'h500;
            3'd4: off = 32'h600;
            3'd5: off = 32'h700;
            3'd6: off = 32'h1000;
            default: return 32'h0;
        endcase
        return (ip ? 32'hFFF0_0000 : 32'h0) | off;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        rst_req = 0; mchk_req = 0; ext_req = 0; ins_valid = 0; ins_class = 0;
        ins_size = 0; ins_pc = 0; ins_ea_lo = 0; ins_spr_top = 0; older_busy = 0;
        late_err = 0; stat_wr_en = 0; stat_wr_val = 0;
    endtask

    task automatic set_status(input logic [4:0] v);
        @(negedge clk); idle(); stat_wr_en = 1; stat_wr_val = v;
        @(negedge clk); stat_wr_en = 0;
    endtask

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk("R1 status after reset", 32'(status), 32'h0);
        chk("R1 save0 after reset", save0, 32'h0);
        chk("R1 save1 after reset", 32'(save1), 32'h0);
        chk("R1 take idle", 32'(exc_take), 32'h0);
        chk("R1 abort idle", 32'(mem_abort), 32'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [31:0] pc;
            logic tk;
            string tg;
            v  = VT[i];
            pc = 32'h0000_1000 + 32'(i) * 4;
            tk = (v.kind != 3'd0);
            tg = $sformatf("vec%0d", i);
            set_status(v.st);
            ins_valid = 1; ins_class = v.cls; ins_ea_lo = v.ea; ins_size = v.sz;
            ins_spr_top = v.spr; ins_pc = pc;
            rst_req = v.q_rst; mchk_req = v.q_mck; ext_req = v.q_ext;
            #1;
            chk({tg, " R3 kind"}, 32'(exc_kind), 32'(v.kind));
            chk({tg, " R3 take"}, 32'(exc_take), 32'(tk));
            chk({tg, " R2 vector"}, exc_vector, exp_vec(v.kind, v.st[4]));
            chk({tg, " R11 issue"}, 32'(mem_issue), 32'(v.issue));
            @(negedge clk);
            if (tk) begin
                chk({tg, " R9 save0"}, save0, pc);
                chk({tg, " R9 save1"}, 32'(save1), 32'(v.st));
                chk({tg, " R9 status"}, 32'(status), 32'(v.st & 5'b11010));
            end else begin
                chk({tg, " R10 status"}, 32'(status), 32'(v.st));
            end
        end

        // R11: busy older instruction blocks fault and issue
        set_status(5'b01000);
        ins_valid = 1; ins_class = 4'd2; ins_size = 2'd2; ins_ea_lo = 3'd2;
        ins_pc = 32'h2000; older_busy = 1;
        #1;
        chk("R11 busy no take", 32'(exc_take), 32'h0);
        chk("R11 busy no issue", 32'(mem_issue), 32'h0);
        @(negedge clk);
        older_busy = 0;
        #1;
        chk("R11 fault after busy clears", 32'(exc_kind), 32'd4);
        @(negedge clk);
        chk("R11 save0 of faulting op", save0, 32'h2000);

        // R12: late error aborts last issue
        set_status(5'b00010);
        ins_valid = 1; ins_class = 4'd3; ins_size = 2'd2; ins_ea_lo = 3'd0;
        ins_pc = 32'h3000;
        #1;
        chk("R12 store issued", 32'(mem_issue), 32'h1);
        @(negedge clk);
        ins_class = 4'd1; ins_pc = 32'h3004; late_err = 1;
        #1;
        chk("R12 abort", 32'(mem_abort), 32'h1);
        chk("R12 mchk kind", 32'(exc_kind), 32'd2);
        chk("R12 vector", exc_vector, 32'h200);
        @(negedge clk);
        chk("R12 save0 aborted pc", save0, 32'h3000);
        late_err = 1; ins_pc = 32'h3008;
        #1;
        chk("R12 no abort without issue", 32'(mem_abort), 32'h0);
        chk("R12 no take without issue", 32'(exc_take), 32'h0);

        // R9: entry beats a same-cycle status write
        set_status(5'b00110);
        rst_req = 1; stat_wr_en = 1; stat_wr_val = 5'b11111; ins_pc = 32'h4000;
        @(negedge clk);
        chk("R9 save1 old status", 32'(save1), 32'h06);
        chk("R9 write dropped", 32'(status), 32'h02);
        idle();

        // R1: reset mid-run
        set_status(5'b11111);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk("R1 status cleared", 32'(status), 32'h0);
        chk("R1 save0 cleared", save0, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule